// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Alarm Wake

The block keeps wall-clock time as packed calendar fields and serves it over a simple 32-bit register bus. One word holds month, day, hour, minute, second and a 1/16 s fraction. A second word holds the year as a plain binary count. The count advances on a slow tick pulse (one tick per 1/16 s, derived from a 32.768 kHz crystal) while both the count enable and the oscillator enable are set. Every field carries into the next: fraction, seconds, minutes, hours, days (month length with leap-year February), months and years.

Software sets the time in two steps. It stages the calendar word, then writes the year, and that write loads both words in the same cycle. Reading the calendar word also freezes a copy of the year, so the next year read agrees with it even if a year carry happened in between. Three alarm words each compare year (low 6 bits only), month, day, hour, minute and second against the running time. A hit sets a wake status bit, which is cleared by writing 1, and a wake-enable bit gates it onto the wake output. A hit on alarm 0 stays latched until software writes zero to alarm 0.

Bus protocol: `req_i` high for one cycle starts an access, and `we_i` selects a write. Read data appears on `rdata_o` in the cycle after the request and holds until the next read.

Top module: `caltime`

## Requirements
- R1: After reset the calendar word reads 0x04200000 (month 1, day 1, all else 0), the year reads 0, the status reads 0 and `wake_o` is 0.
- R2: The time advances by one fraction step per `tick_i` pulse only while control (offset 0x00) has bit 0 (count enable) and bit 1 (oscillator enable) both set. Otherwise it holds.
- R3: The calendar word packs month [31:26], day [25:21], hour [20:16], minute [15:10], second [9:4] and fraction [3:0]. Fraction wraps from 15 to 0 into seconds, seconds and minutes wrap at 59, and hours wrap at 23.
- R4: The day wraps to 1 after the last day of the month (30 for months 4, 6, 9 and 11; February 29 when the year is divisible by 4 and not by 100, or divisible by 400; otherwise 28; 31 for the rest). Month 12 wraps to 1 and increments the year.
- R5: A write to the stage register (0x04) changes nothing visible. A write to the commit register (0x08) loads the staged calendar word and the written year (low 16 bits) into the counter in one cycle, and this takes priority over a tick in that cycle.
- R6: A read of the calendar word (0x0C) captures the current year. A read of the year register (0x10) returns the last captured year.
- R7: Alarm words at 0x14, 0x18 and 0x1C pack year-low-6 [31:26], month [25:22], day [21:17], hour [16:12], minute [11:6] and second [5:0]. When all fields equal the current time, status bit 0 (0x20) is set at the next clock edge. A month of 0 never matches.
- R8: Writing 1 to status bit 0 clears it unless a set occurs in the same cycle. Writing 0 has no effect. `wake_o` equals status bit 0 AND wake-enable bit 0 (0x24).
- R9: A hit on alarm 0 is latched and re-sets the status every cycle until software writes zero to alarm 0.
- R10: The stage and commit registers read as 0. Writes to the calendar-read and year-read offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse every 1/16 s |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| wake_o | output | 1 | Wake event, status AND enable |

## Verification
A wrong carry or month length stays inside the counter until a read of the calendar word exposes it. It then persists in every later read, so the bench compares each read against a behavioural calendar model and drives the time across every rollover boundary. A lost or spurious alarm latch shows on `wake_o` one cycle after the faulty edge, so `wake_o` is compared against the model on every clock. A stale year snapshot shows only on a year read that follows a year carry, and that sequence is forced on purpose.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  typedef struct packed {
    logic [5:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
    logic [3:0] frac;
  } cal_low_t;

  localparam cal_low_t CAL_RESET = '{mon: 6'd1, day: 5'd1, hour: 5'd0,
                                     minute: 6'd0, second: 6'd0, frac: 4'd0};

  function automatic logic is_leap(input logic [31:0] y);
    return (y[1:0] == 2'b00) && (((y % 32'd100) != 32'd0) || ((y % 32'd400) == 32'd0));
  endfunction

  function automatic logic [4:0] month_days(input logic [5:0] m, input logic leap);
    case (m)
      6'd2:                      return leap ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/caltime_counter.sv
module caltime_counter
  import caltime_pkg::*;
#(
  parameter int YEAR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  cal_low_t          load_low_i,
  input  logic [YEAR_W-1:0] load_year_i,
  output cal_low_t          now_o,
  output logic [YEAR_W-1:0] year_o
);

  cal_low_t          now_q, nxt;
  logic [YEAR_W-1:0] year_q, year_nxt;
  logic [4:0]        last_day;
  logic              c_frac, c_sec, c_min, c_hr, c_day, c_mon;

  assign last_day = month_days(now_q.mon, is_leap(32'(year_q)));

  always_comb begin
    c_frac = now_q.frac == 4'hf;
    c_sec  = c_frac && now_q.second >= 6'd59;
    c_min  = c_sec  && now_q.minute >= 6'd59;
    c_hr   = c_min  && now_q.hour   >= 5'd23;
    c_day  = c_hr   && now_q.day    >= last_day;
    c_mon  = c_day  && now_q.mon    >= 6'd12;
    nxt      = now_q;
    nxt.frac = now_q.frac + 4'd1;
    if (c_frac) nxt.second = c_sec ? 6'd0 : now_q.second + 6'd1;
    if (c_sec)  nxt.minute = c_min ? 6'd0 : now_q.minute + 6'd1;
    if (c_min)  nxt.hour   = c_hr  ? 5'd0 : now_q.hour + 5'd1;
    if (c_hr)   nxt.day    = c_day ? 5'd1 : now_q.day + 5'd1;
    if (c_day)  nxt.mon    = c_mon ? 6'd1 : now_q.mon + 6'd1;
    year_nxt = c_mon ? year_q + 1'b1 : year_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q  <= CAL_RESET;
      year_q <= '0;
    end else if (load_i) begin
      now_q  <= load_low_i;
      year_q <= load_year_i;
    end else if (step_i) begin
      now_q  <= nxt;
      year_q <= year_nxt;
    end
  end

  assign now_o  = now_q;
  assign year_o = year_q;

  // R5
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (now_q == $past(load_low_i)) && (year_q == $past(load_year_i)));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(now_q) && $stable(year_q)));

  // R3
  frac_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && now_q.frac != 4'hf) |=> (now_q.second == $past(now_q.second)));

endmodule

// File: rtl/caltime_match.sv
module caltime_match
  import caltime_pkg::*;
#(
  parameter int N_MATCH = 3
) (
  input  cal_low_t                  now_i,
  input  logic [5:0]                year_lo_i,
  input  logic [N_MATCH-1:0][31:0]  match_i,
  output logic [N_MATCH-1:0]        hit_o
);

  for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
    assign hit_o[g] = (match_i[g][31:26] == year_lo_i)
                   && ({2'b00, match_i[g][25:22]} == now_i.mon)
                   && (match_i[g][21:17] == now_i.day)
                   && (match_i[g][16:12] == now_i.hour)
                   && (match_i[g][11:6]  == now_i.minute)
                   && (match_i[g][5:0]   == now_i.second);
  end

endmodule

// File: rtl/caltime.sv
module caltime
  import caltime_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int YEAR_W  = 16,
  parameter int N_MATCH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wake_o
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STAGE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_COMMT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_RLOW  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_RYEAR = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_WEN   = ADDR_W'('h24);

  logic                     wr, rd;
  logic                     cnt_en_q, osc_en_q, wake_en_q, status_q, pend0_q;
  logic [31:0]              stage_q, rd_mux, rdata_q;
  logic [N_MATCH-1:0][31:0] match_q;
  logic [N_MATCH-1:0]       hit;
  logic [YEAR_W-1:0]        year, snap_q;
  logic                     load, step, clr0, sts_clr, sts_set;
  cal_low_t                 now;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign load    = wr && addr_i == A_COMMT;
  assign step    = tick_i && cnt_en_q && osc_en_q;
  assign clr0    = wr && addr_i == A_MATCH && wdata_i == 32'd0;
  assign sts_clr = wr && addr_i == A_STS && wdata_i[0];
  assign sts_set = (|hit) || pend0_q;

  caltime_counter #(.YEAR_W(YEAR_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .load_i      (load),
    .load_low_i  (cal_low_t'(stage_q)),
    .load_year_i (wdata_i[YEAR_W-1:0]),
    .now_o       (now),
    .year_o      (year)
  );

  caltime_match #(.N_MATCH(N_MATCH)) u_match (
    .now_i     (now),
    .year_lo_i (year[5:0]),
    .match_i   (match_q),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_en_q  <= 1'b0;
      osc_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
      stage_q   <= '0;
      match_q   <= '0;
    end else if (wr) begin
      if (addr_i == A_CTRL) begin
        cnt_en_q <= wdata_i[0];
        osc_en_q <= wdata_i[1];
      end
      if (addr_i == A_STAGE) stage_q   <= wdata_i;
      if (addr_i == A_WEN)   wake_en_q <= wdata_i[0];
      for (int i = 0; i < N_MATCH; i++) begin
        if (addr_i == A_MATCH + ADDR_W'(4 * i)) match_q[i] <= wdata_i;
      end
    end
  end

  // sticky alarm-0 latch and write-1-clear status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend0_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      pend0_q  <= clr0 ? 1'b0 : (pend0_q || hit[0]);
      status_q <= sts_set || (status_q && !sts_clr);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL:  rd_mux = {30'd0, osc_en_q, cnt_en_q};
      A_RLOW:  rd_mux = now;
      A_RYEAR: rd_mux = 32'(snap_q);
      A_STS:   rd_mux = {31'd0, status_q};
      A_WEN:   rd_mux = {31'd0, wake_en_q};
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++) begin
      if (addr_i == A_MATCH + ADDR_W'(4 * i)) rd_mux = match_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (rd) begin
      rdata_q <= rd_mux;
      if (addr_i == A_RLOW) snap_q <= year;
    end
  end

  assign rdata_o = rdata_q;
  assign wake_o  = status_q && wake_en_q;

  // R7
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past((|hit) || pend0_q));

  // R8
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr && !sts_set) |=> !status_q);

  // R9
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend0_q && !clr0) |=> (pend0_q && status_q));

endmodule

// File: tb/caltime_tb.sv
`timescale 1ns/1ps
module caltime_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake;

  int n_chk = 0, n_fail = 0;

  int m_frac, m_sec, m_min, m_hour, m_day, m_mon, m_year;
  int m_cnt, m_osc, m_en, m_sts, m_pend, m_snap;
  logic [31:0] m_stage;
  logic [31:0] m_match [3];

  always #5 clk = ~clk;

  caltime u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wake_o(wake)
  );

  function automatic int leap(int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] tw(int mo, int d, int h, int mi, int s, int f);
    return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) | (32'(s) << 4) | 32'(f);
  endfunction

  function automatic logic [31:0] mw(int y, int mo, int d, int h, int mi, int s);
    return (32'(y % 64) << 26) | (32'(mo) << 22) | (32'(d) << 17) | (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_frac = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0;
    m_cnt = 0; m_osc = 0; m_en = 0; m_sts = 0; m_pend = 0; m_snap = 0; m_stage = 0;
    for (int i = 0; i < 3; i++) m_match[i] = 0;
  endtask

  task automatic model_adv();
    m_frac++;
    if (m_frac == 16) begin
      m_frac = 0; m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hour++;
          if (m_hour == 24) begin
            m_hour = 0; m_day++;
            if (m_day > mdays(m_mon, m_year)) begin
              m_day = 1; m_mon++;
              if (m_mon == 13) begin
                m_mon = 1; m_year = (m_year + 1) % 65536;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic model_step(input logic t, input logic r, input logic w, input logic [5:0] a,
                            input logic [31:0] d, output logic [31:0] exp_rd);
    int h [3];
    int set, npend, nsts;
    logic wr, rdq;
    wr = r && w; rdq = r && !w;
    for (int i = 0; i < 3; i++)
      h[i] = (int'(m_match[i][31:26]) == m_year % 64) && (int'(m_match[i][25:22]) == m_mon) &&
             (int'(m_match[i][21:17]) == m_day) && (int'(m_match[i][16:12]) == m_hour) &&
             (int'(m_match[i][11:6]) == m_min) && (int'(m_match[i][5:0]) == m_sec);
    set = h[0] | h[1] | h[2] | m_pend;
    case (a)
      6'h00:   exp_rd = 32'(m_cnt | (m_osc << 1));
      6'h0C:   exp_rd = tw(m_mon, m_day, m_hour, m_min, m_sec, m_frac);
      6'h10:   exp_rd = 32'(m_snap);
      6'h14:   exp_rd = m_match[0];
      6'h18:   exp_rd = m_match[1];
      6'h1C:   exp_rd = m_match[2];
      6'h20:   exp_rd = 32'(m_sts);
      6'h24:   exp_rd = 32'(m_en);
      default: exp_rd = 0;
    endcase
    npend = (wr && a == 6'h14 && d == 0) ? 0 : (m_pend | h[0]);
    nsts  = set | (m_sts & !(wr && a == 6'h20 && d[0]));
    if (rdq && a == 6'h0C) m_snap = m_year;
    if (wr && a == 6'h08) begin
      m_mon = int'(m_stage[31:26]); m_day = int'(m_stage[25:21]); m_hour = int'(m_stage[20:16]);
      m_min = int'(m_stage[15:10]); m_sec = int'(m_stage[9:4]); m_frac = int'(m_stage[3:0]);
      m_year = int'(d[15:0]);
    end else if (t && m_cnt && m_osc) model_adv();
    if (wr) begin
      if (a == 6'h00) begin m_cnt = int'(d[0]); m_osc = int'(d[1]); end
      if (a == 6'h04) m_stage = d;
      if (a == 6'h24) m_en = int'(d[0]);
      if (a == 6'h14) m_match[0] = d;
      if (a == 6'h18) m_match[1] = d;
      if (a == 6'h1C) m_match[2] = d;
    end
    m_pend = npend; m_sts = nsts;
  endtask

  task automatic cyc(input logic t, input logic r, input logic w, input logic [5:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    tick = t; req = r; we = w; addr = a; wdata = d;
    model_step(t, r, w, a, d, exp_rd);
    @(posedge clk);
    @(negedge clk);
    tick = 0; req = 0; we = 0;
    chk("R8 wake", {31'd0, wake}, 32'(m_sts & m_en));
    if (r && !w) chk(tag, rdata, exp_rd);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b1, a, d, "");
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 6'h00, 32'd0, "");
  endtask

  task automatic set_time(int y, int mo, int d, int h, int mi, int s, int f);
    wr(6'h04, tw(mo, d, h, mi, s, f));
    wr(6'h08, 32'(y));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(6'h0C, "R1 low");   chk("R1 low const", rdata, 32'h0420_0000);
    rd(6'h10, "R1 year");  chk("R1 year const", rdata, 32'd0);
    rd(6'h20, "R1 status"); chk("R1 wake", {31'd0, wake}, 32'd0);

    // R2 enables
    tk(5); rd(6'h0C, "R2 both off"); chk("R2 both off const", rdata, 32'h0420_0000);
    wr(6'h00, 32'd1); tk(5); rd(6'h0C, "R2 osc off"); chk("R2 osc off const", rdata, 32'h0420_0000);
    wr(6'h00, 32'd3); tk(3); rd(6'h0C, "R2 running"); chk("R2 running const", rdata, 32'h0420_0003);

    // R5 stage then commit
    wr(6'h04, tw(2, 28, 23, 59, 59, 14));
    rd(6'h0C, "R5 staged only"); chk("R5 staged const", rdata, 32'h0420_0003);
    wr(6'h08, 32'd2024);
    rd(6'h0C, "R5 committed"); chk("R5 committed const", rdata, tw(2, 28, 23, 59, 59, 14));
    rd(6'h10, "R5 year"); chk("R5 year const", rdata, 32'd2024);

    // R4 month ends
    tk(2); rd(6'h0C, "R4 leap feb"); chk("R4 leap feb const", rdata, tw(2, 29, 0, 0, 0, 0));
    set_time(2023, 2, 28, 23, 59, 59, 15); tk(1);
    rd(6'h0C, "R4 common feb"); chk("R4 common feb const", rdata, tw(3, 1, 0, 0, 0, 0));
    set_time(2100, 2, 28, 23, 59, 59, 15); tk(1);
    rd(6'h0C, "R4 century feb"); chk("R4 century feb const", rdata, tw(3, 1, 0, 0, 0, 0));
    set_time(2000, 2, 28, 23, 59, 59, 15); tk(1);
    rd(6'h0C, "R4 400 feb"); chk("R4 400 feb const", rdata, tw(2, 29, 0, 0, 0, 0));
    set_time(2001, 4, 30, 23, 59, 59, 15); tk(1);
    rd(6'h0C, "R4 april"); chk("R4 april const", rdata, tw(5, 1, 0, 0, 0, 0));
    set_time(2030, 12, 31, 23, 59, 59, 15); tk(1);
    rd(6'h0C, "R4 new year"); chk("R4 new year const", rdata, tw(1, 1, 0, 0, 0, 0));
    rd(6'h10, "R4 year inc"); chk("R4 year inc const", rdata, 32'd2031);

    // R3 carries
    set_time(2031, 5, 6, 10, 59, 59, 15); tk(1);
    rd(6'h0C, "R3 hour carry"); chk("R3 hour carry const", rdata, tw(5, 6, 11, 0, 0, 0));
    set_time(2031, 5, 6, 3, 7, 59, 15); tk(1);
    rd(6'h0C, "R3 min carry"); chk("R3 min carry const", rdata, tw(5, 6, 3, 8, 0, 0));

    // R6 snapshot across a year carry
    set_time(2040, 12, 31, 23, 59, 59, 15);
    rd(6'h0C, "R6 low read"); tk(1);
    rd(6'h10, "R6 snapshot"); chk("R6 snapshot const", rdata, 32'd2040);
    rd(6'h0C, "R6 relow"); rd(6'h10, "R6 fresh"); chk("R6 fresh const", rdata, 32'd2041);

    // R10 write-only / read-only
    rd(6'h04, "R10 stage reads 0"); rd(6'h08, "R10 commit reads 0");
    wr(6'h0C, 32'hffff_ffff); wr(6'h10, 32'hffff_ffff);
    rd(6'h0C, "R10 ro low"); chk("R10 ro low const", rdata, tw(1, 1, 0, 0, 0, 0));
    rd(6'h0C, "R10 relow"); rd(6'h10, "R10 ro year"); chk("R10 ro year const", rdata, 32'd2041);

    // R7 alarm on 6-bit year
    wr(6'h24, 32'd1);
    set_time(2106, 6, 15, 12, 30, 10, 0);
    wr(6'h18, mw(2042, 6, 15, 12, 30, 11));
    tk(15); rd(6'h20, "R7 not yet"); chk("R7 not yet const", rdata, 32'd0);
    tk(1); tk(1);
    chk("R7 wake set", {31'd0, wake}, 32'd1);
    rd(6'h20, "R7 status");

    // R8 clear and gating
    tk(16);
    wr(6'h20, 32'd0); rd(6'h20, "R8 write0 no effect"); chk("R8 write0 const", rdata, 32'd1);
    wr(6'h24, 32'd0); chk("R8 gated wake", {31'd0, wake}, 32'd0);
    wr(6'h24, 32'd1);
    wr(6'h20, 32'd1); rd(6'h20, "R8 cleared"); chk("R8 cleared const", rdata, 32'd0);

    // R9 sticky alarm 0
    wr(6'h18, 32'd0);
    wr(6'h14, mw(2106, 6, 15, 12, 30, 20));
    tk(16 * 10);
    wr(6'h20, 32'd1); rd(6'h20, "R9 sticky"); chk("R9 sticky const", rdata, 32'd1);
    wr(6'h14, 32'd0); wr(6'h20, 32'd1);
    rd(6'h20, "R9 released"); chk("R9 released const", rdata, 32'd0);

    // mixed traffic across a leap-year new year with an alarm
    set_time(2043, 12, 31, 23, 58, 50, 0);
    wr(6'h1C, mw(2044, 1, 1, 0, 0, 5));
    begin
      logic [31:0] lcg;
      lcg = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        case (lcg[31:29])
          3'd0: rd(6'h0C, "R3 mixed low");
          3'd1: rd(6'h10, "R6 mixed year");
          3'd2: rd(6'h20, "R7 mixed status");
          3'd3: if (lcg[8:0] == 9'd0) wr(6'h20, 32'd1); else tk(1);
          default: cyc(lcg[20], 1'b0, 1'b0, 6'h00, 32'd0, "");
        endcase
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule